// File: doc/BRIEF.md
# Integer-N Synthesizer Divider and Phase Detector

This block is the digital heart of an integer-N frequency synthesizer. A reference divider turns a stream of reference ticks into a slow comparison pulse. Its ratio is chosen from three values. A 15-bit programmable counter divides the ticks of the already prescaled oscillator (an external fixed divide-by-8 stage) by N. A phase-frequency detector compares the two divided pulses and produces charge pump commands. A lock detector watches the width of those commands. The loop settles at fOSC = 8 × N × fREF / R. With a 4 MHz reference and R = 1024, the channel step is 31.25 kHz, and N = 16544 gives 517 MHz.

Everything runs on one system clock. The reference and the prescaled oscillator enter as one-cycle enable strobes (`refEn`, `vcoEn`), so the divider counts are counts of strobes. The pump outputs can be overridden by a test selector. This lets the analog pump be driven high, driven low or floated whatever the phase comparison says. The divided pulses are brought out for observation.

Top module: `synth_core`

## Requirements
- R1: `refPulse` is high for exactly one cycle once every R `refEn` strobes, where `refSel` selects R: 2'b01 gives 512, 2'b10 gives 640, and 2'b00 or 2'b11 give 1024. The pulse appears in the cycle after the strobe that ends the count. The first strobe after reset ends a count.
- R2: `vcoPulse` is high for exactly one cycle once every N `vcoEn` strobes, with N = `divN` for 1024..32767 and `divN` = 0 meaning 32768. The pulse appears in the cycle after the terminal strobe. The first strobe after reset is terminal.
- R3: A `divN` value from 1 to 1023 divides by 1024.
- R4: A change of `divN` or `refSel` is taken only when the counter reloads at its terminal strobe. The period in progress finishes with the old value, and the next period uses the new one.
- R5: The cycle after `refPulse`, the internal up command is set. The cycle after `vcoPulse`, the down command is set. One cycle after both are set, both clear. With `pumpTest` = 2'b00, `pumpUp` and `pumpDn` show these commands and `pumpDrive` is 1.
- R6: `pumpTest` = 2'b01 floats the pump: `pumpDrive`, `pumpUp` and `pumpDn` are all 0. 2'b10 forces sink: `pumpDn`=1, `pumpUp`=0, `pumpDrive`=1. 2'b11 forces source: `pumpUp`=1, `pumpDn`=0, `pumpDrive`=1.
- R7: During reset, `pumpUp`, `pumpDn`, `refPulse`, `vcoPulse` and `locked` are 0, and `pumpDrive` follows `pumpTest` as in R5/R6.
- R8: `locked` rises in the cycle after the `refPulse` that closes the 4th consecutive reference period in which neither command stayed high for 2 or more consecutive cycles. `locked` changes only in the cycle after a `refPulse`.
- R9: `locked` falls in the cycle after the `refPulse` that closes the first period containing a command high for 2 or more consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refEn | input | 1 | One-cycle strobe per reference clock edge |
| vcoEn | input | 1 | One-cycle strobe per prescaled oscillator edge |
| divN | input | 15 | Main division ratio N (0 means 32768) |
| refSel | input | 2 | Reference ratio select |
| pumpTest | input | 2 | Pump override: normal, float, sink, source |
| pumpUp | output | 1 | Pump source command |
| pumpDn | output | 1 | Pump sink command |
| pumpDrive | output | 1 | 1 = pump driven, 0 = high impedance |
| refPulse | output | 1 | Divided reference pulse |
| vcoPulse | output | 1 | Divided oscillator pulse |
| locked | output | 1 | Lock flag |

## Verification
The checker watches four things on every cycle: the one-cycle shape of both divided pulses, the span of strobes between oscillator pulses, the set-and-clear rules of the detector, and the three override modes at the pump pins. It also checks that the lock flag only moves right after a reference pulse. Some points only the bench scenarios can show. These are the exact ratio chosen by each select code, the clamp of small N, and the deferral of a new N to the terminal count. They also include the cycle in which lock is gained after four clean periods and the cycle in which it is lost after one period with a two-cycle pump command.

// File: rtl/synth_core_pkg.sv
package synth_core_pkg;

  // Pump override strobes from control to datapath
  typedef struct packed {
    logic forceUp;
    logic forceDn;
    logic floatOut;
  } pumpCmd_t;

endpackage

// File: rtl/pulse_divider.sv
// Down-counter divider: emits a one-cycle pulse after the terminal tick and
// reloads from reloadVal only at that moment.
module pulse_divider #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic [W-1:0] reloadVal,
  output logic         pulse
);

  logic [W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      pulse <= 1'b0;
    end else if (tick) begin
      if (count == '0) begin
        count <= reloadVal;
        pulse <= 1'b1;
      end else begin
        count <= count - 1'b1;
        pulse <= 1'b0;
      end
    end else begin
      pulse <= 1'b0;
    end
  end

endmodule

// File: rtl/synth_datapath.sv
module synth_datapath
  import synth_core_pkg::*;
#(
  parameter int N_WIDTH = 15,
  parameter int N_MIN   = 1024,
  parameter int RATIO_A = 1024,
  parameter int RATIO_B = 512,
  parameter int RATIO_C = 640
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refEn,
  input  logic               vcoEn,
  input  logic [N_WIDTH-1:0] divN,
  input  logic [1:0]         refSel,
  input  pumpCmd_t           pumpCmd,
  output logic               refPulse,
  output logic               vcoPulse,
  output logic               pfdUp,
  output logic               pfdDn,
  output logic               pumpUp,
  output logic               pumpDn,
  output logic               pumpDrive
);

  localparam int RMAX_AB = (RATIO_A > RATIO_B) ? RATIO_A : RATIO_B;
  localparam int RMAX    = (RMAX_AB > RATIO_C) ? RMAX_AB : RATIO_C;
  localparam int REF_W   = $clog2(RMAX);

  logic [REF_W-1:0]   refReload;
  logic [N_WIDTH-1:0] mainReload;

  always_comb begin
    unique case (refSel)
      2'b01:   refReload = REF_W'(RATIO_B - 1);
      2'b10:   refReload = REF_W'(RATIO_C - 1);
      default: refReload = REF_W'(RATIO_A - 1);
    endcase
  end

  // Zero selects the full 2^N_WIDTH span; small values clamp to the minimum
  always_comb begin
    if (divN == '0)
      mainReload = '1;
    else if (divN < N_WIDTH'(N_MIN))
      mainReload = N_WIDTH'(N_MIN - 1);
    else
      mainReload = divN - 1'b1;
  end

  pulse_divider #(.W(REF_W)) refDiv (
    .clk(clk), .rstN(rstN), .tick(refEn),
    .reloadVal(refReload), .pulse(refPulse)
  );

  pulse_divider #(.W(N_WIDTH)) mainDiv (
    .clk(clk), .rstN(rstN), .tick(vcoEn),
    .reloadVal(mainReload), .pulse(vcoPulse)
  );

  // Phase-frequency detector
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pfdUp <= 1'b0;
      pfdDn <= 1'b0;
    end else if (pfdUp && pfdDn) begin
      pfdUp <= refPulse;
      pfdDn <= vcoPulse;
    end else begin
      pfdUp <= pfdUp | refPulse;
      pfdDn <= pfdDn | vcoPulse;
    end
  end

  always_comb begin
    pumpDrive = !pumpCmd.floatOut;
    if (pumpCmd.floatOut) begin
      pumpUp = 1'b0;
      pumpDn = 1'b0;
    end else if (pumpCmd.forceUp) begin
      pumpUp = 1'b1;
      pumpDn = 1'b0;
    end else if (pumpCmd.forceDn) begin
      pumpUp = 1'b0;
      pumpDn = 1'b1;
    end else begin
      pumpUp = pfdUp;
      pumpDn = pfdDn;
    end
  end

endmodule

// File: rtl/synth_control.sv
module synth_control
  import synth_core_pkg::*;
#(
  parameter int LOCK_PERIODS = 4,
  parameter int WIDTH_LIMIT  = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic [1:0] pumpTest,
  input  logic     refPulse,
  input  logic     pfdUp,
  input  logic     pfdDn,
  output pumpCmd_t pumpCmd,
  output logic     locked
);

  localparam int LOCK_W = (LOCK_PERIODS > 1) ? $clog2(LOCK_PERIODS) : 1;
  localparam int RUN_W  = $clog2(WIDTH_LIMIT + 1);

  logic [RUN_W-1:0]  upRun, dnRun;
  logic [LOCK_W-1:0] goodCnt;
  logic              badSeen;
  logic              violNow;

  always_comb begin
    pumpCmd.floatOut = (pumpTest == 2'b01);
    pumpCmd.forceDn  = (pumpTest == 2'b10);
    pumpCmd.forceUp  = (pumpTest == 2'b11);
  end

  assign violNow = (pfdUp && upRun >= RUN_W'(WIDTH_LIMIT - 1)) ||
                   (pfdDn && dnRun >= RUN_W'(WIDTH_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upRun <= '0;
      dnRun <= '0;
    end else begin
      upRun <= !pfdUp ? '0 : (upRun == '1 ? upRun : upRun + 1'b1);
      dnRun <= !pfdDn ? '0 : (dnRun == '1 ? dnRun : dnRun + 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      goodCnt <= '0;
      badSeen <= 1'b0;
      locked  <= 1'b0;
    end else if (refPulse) begin
      badSeen <= violNow;
      if (badSeen) begin
        goodCnt <= '0;
        locked  <= 1'b0;
      end else if (goodCnt == LOCK_W'(LOCK_PERIODS - 1)) begin
        locked  <= 1'b1;
      end else begin
        goodCnt <= goodCnt + 1'b1;
      end
    end else begin
      badSeen <= badSeen | violNow;
    end
  end

endmodule

// File: rtl/synth_core.sv
module synth_core
  import synth_core_pkg::*;
#(
  parameter int N_WIDTH      = 15,
  parameter int N_MIN        = 1024,
  parameter int RATIO_A      = 1024,
  parameter int RATIO_B      = 512,
  parameter int RATIO_C      = 640,
  parameter int LOCK_PERIODS = 4,
  parameter int WIDTH_LIMIT  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refEn,
  input  logic               vcoEn,
  input  logic [N_WIDTH-1:0] divN,
  input  logic [1:0]         refSel,
  input  logic [1:0]         pumpTest,
  output logic               pumpUp,
  output logic               pumpDn,
  output logic               pumpDrive,
  output logic               refPulse,
  output logic               vcoPulse,
  output logic               locked
);

  pumpCmd_t pumpCmd;
  logic     pfdUp, pfdDn;

  synth_datapath #(
    .N_WIDTH(N_WIDTH), .N_MIN(N_MIN),
    .RATIO_A(RATIO_A), .RATIO_B(RATIO_B), .RATIO_C(RATIO_C)
  ) datapath (
    .clk(clk), .rstN(rstN), .refEn(refEn), .vcoEn(vcoEn),
    .divN(divN), .refSel(refSel), .pumpCmd(pumpCmd),
    .refPulse(refPulse), .vcoPulse(vcoPulse),
    .pfdUp(pfdUp), .pfdDn(pfdDn),
    .pumpUp(pumpUp), .pumpDn(pumpDn), .pumpDrive(pumpDrive)
  );

  synth_control #(
    .LOCK_PERIODS(LOCK_PERIODS), .WIDTH_LIMIT(WIDTH_LIMIT)
  ) control (
    .clk(clk), .rstN(rstN), .pumpTest(pumpTest),
    .refPulse(refPulse), .pfdUp(pfdUp), .pfdDn(pfdDn),
    .pumpCmd(pumpCmd), .locked(locked)
  );

endmodule

// File: rtl/synth_core_checker.sv
module synth_core_checker #(
  parameter int N_MIN = 1024,
  parameter int N_MAX = 32768
) (
  input logic       clk,
  input logic       rstN,
  input logic       vcoEn,
  input logic [1:0] pumpTest,
  input logic       pumpUp,
  input logic       pumpDn,
  input logic       pumpDrive,
  input logic       refPulse,
  input logic       vcoPulse,
  input logic       locked
);

  localparam int CW = $clog2(N_MAX) + 2;

  logic [CW-1:0] tickCnt;
  logic          seenVco;

  // Strobes counted since the previous divided oscillator pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
      seenVco <= 1'b0;
    end else if (vcoPulse) begin
      tickCnt <= vcoEn ? CW'(1) : '0;
      seenVco <= 1'b1;
    end else if (vcoEn && tickCnt != '1) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  assert_ref_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    refPulse |=> !refPulse);

  assert_vco_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    vcoPulse |=> !vcoPulse);

  assert_vco_span_R3: assert property (@(posedge clk) disable iff (!rstN)
    (vcoPulse && seenVco) |-> (tickCnt >= CW'(N_MIN) && tickCnt <= CW'(N_MAX)));

  assert_up_after_ref_R5: assert property (@(posedge clk) disable iff (!rstN)
    refPulse |=> (pumpTest != 2'b00 || pumpUp));

  assert_pfd_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pumpTest == 2'b00 && pumpUp && pumpDn && !refPulse && !vcoPulse)
      |=> (pumpTest != 2'b00 || (!pumpUp && !pumpDn)));

  assert_float_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pumpTest == 2'b01) |-> (!pumpDrive && !pumpUp && !pumpDn));

  assert_sink_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pumpTest == 2'b10) |-> (pumpDrive && pumpDn && !pumpUp));

  assert_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pumpTest == 2'b11) |-> (pumpDrive && pumpUp && !pumpDn));

  assert_lock_moves_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(locked) |-> $past(refPulse));

endmodule

bind synth_core synth_core_checker chk (
  .clk(clk), .rstN(rstN), .vcoEn(vcoEn), .pumpTest(pumpTest),
  .pumpUp(pumpUp), .pumpDn(pumpDn), .pumpDrive(pumpDrive),
  .refPulse(refPulse), .vcoPulse(vcoPulse), .locked(locked)
);

// File: tb/synth_core_test.sv
module synth_core_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refEn = 1'b0;
  logic        vcoEn = 1'b0;
  logic [14:0] divN = 15'd1024;
  logic [1:0]  refSel = 2'b00;
  logic [1:0]  pumpTest = 2'b00;
  logic        pumpUp, pumpDn, pumpDrive, refPulse, vcoPulse, locked;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  synth_core uut (
    .clk(clk), .rstN(rstN), .refEn(refEn), .vcoEn(vcoEn),
    .divN(divN), .refSel(refSel), .pumpTest(pumpTest),
    .pumpUp(pumpUp), .pumpDn(pumpDn), .pumpDrive(pumpDrive),
    .refPulse(refPulse), .vcoPulse(vcoPulse), .locked(locked)
  );

  // {isRef, refSel, divN, expected period}
  localparam logic [34:0] VECS [9] = '{
    {1'b1, 2'b00, 15'd0,    17'd1024},
    {1'b1, 2'b01, 15'd0,    17'd512},
    {1'b1, 2'b10, 15'd0,    17'd640},
    {1'b1, 2'b11, 15'd0,    17'd1024},
    {1'b0, 2'b00, 15'd1024, 17'd1024},
    {1'b0, 2'b00, 15'd1500, 17'd1500},
    {1'b0, 2'b00, 15'd5,    17'd1024},
    {1'b0, 2'b00, 15'd1023, 17'd1024},
    {1'b0, 2'b00, 15'd0,    17'd32768}
  };

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    refEn = 1'b0;
    vcoEn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Waits for a pulse, then counts cycles to the next one
  task automatic measure(input bit useRef, output int cycles);
    int guard = 0;
    cycles = -1;
    do begin
      @(negedge clk);
      guard++;
    end while (!(useRef ? refPulse : vcoPulse) && guard < 40000);
    if (guard >= 40000) return;
    cycles = 0;
    do begin
      @(negedge clk);
      cycles++;
    end while (!(useRef ? refPulse : vcoPulse) && cycles < 40000);
  endtask

  initial begin
    int period;
    int guard;
    // R7: reset state
    doReset();
    check("R7", "pumpUp in reset", pumpUp, 0);
    check("R7", "pumpDn in reset", pumpDn, 0);
    check("R7", "refPulse in reset", refPulse, 0);
    check("R7", "vcoPulse in reset", vcoPulse, 0);
    check("R7", "locked in reset", locked, 0);
    check("R7", "pumpDrive in reset", pumpDrive, 1);

    // Aligned loop: ref ratio 512 on every other strobe, N=1024 every cycle
    refSel = 2'b01;
    divN = 15'd1024;
    rstN = 1'b1;
    refEn = 1'b1;
    vcoEn = 1'b1;
    for (int i = 0; i < 6400; i++) begin
      @(negedge clk);
      refEn = !refEn;
      if (i == 0) begin
        check("R1", "first refPulse", refPulse, 1);
        check("R2", "first vcoPulse", vcoPulse, 1);
      end
      if (i == 1) begin
        check("R5", "up after coincident pulses", pumpUp, 1);
        check("R5", "dn after coincident pulses", pumpDn, 1);
      end
      if (i == 2) begin
        check("R5", "up cleared", pumpUp, 0);
        check("R5", "dn cleared", pumpDn, 0);
      end
      if (i == 3000) check("R8", "not yet locked", locked, 0);
      if (i == 3073) check("R8", "locked after 4th clean period", locked, 1);
      if (i == 3300) divN = 15'd1025;
      if (i == 5121) begin
        check("R5", "up leads by one cycle", pumpUp, 1);
        check("R5", "dn not yet set", pumpDn, 0);
      end
      if (i == 5122) begin
        check("R5", "up second cycle", pumpUp, 1);
        check("R5", "dn set", pumpDn, 1);
      end
      if (i == 5123) check("R5", "both cleared", pumpUp | pumpDn, 0);
      if (i == 6144) check("R9", "lock held until period closes", locked, 1);
      if (i == 6145) check("R9", "lock dropped", locked, 0);
    end

    // R6: pump overrides
    pumpTest = 2'b01;
    @(negedge clk);
    check("R6", "float drive", pumpDrive, 0);
    check("R6", "float up|dn", pumpUp | pumpDn, 0);
    pumpTest = 2'b10;
    @(negedge clk);
    check("R6", "sink drive", pumpDrive, 1);
    check("R6", "sink dn", pumpDn, 1);
    check("R6", "sink up", pumpUp, 0);
    pumpTest = 2'b11;
    @(negedge clk);
    check("R6", "source drive", pumpDrive, 1);
    check("R6", "source up", pumpUp, 1);
    check("R6", "source dn", pumpDn, 0);
    pumpTest = 2'b00;

    // R4: N change mid-period is deferred to the terminal count
    doReset();
    divN = 15'd1024;
    refSel = 2'b00;
    rstN = 1'b1;
    vcoEn = 1'b1;
    refEn = 1'b1;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!vcoPulse && guard < 100);
    period = 0;
    do begin
      @(negedge clk);
      period++;
      if (period == 300) divN = 15'd1500;
    end while (!vcoPulse && period < 40000);
    check("R4", "period with N changed midway", period, 1024);
    period = 0;
    do begin
      @(negedge clk);
      period++;
    end while (!vcoPulse && period < 40000);
    check("R4", "period after reload", period, 1500);

    // Vector table: R1 ratios, R2/R3 main division
    foreach (VECS[k]) begin
      refSel = VECS[k][33:32];
      divN = VECS[k][31:17];
      measure(VECS[k][34], period);
      measure(VECS[k][34], period);
      if (VECS[k][34])
        check("R1", "reference period", period, int'(VECS[k][16:0]));
      else if (VECS[k][31:17] != 15'd0 && VECS[k][31:17] < 15'd1024)
        check("R3", "clamped main period", period, int'(VECS[k][16:0]));
      else
        check("R2", "main period", period, int'(VECS[k][16:0]));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule